// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block turns parallel signed audio words into a three-wire serial stream made of a bit clock (`sck`), a word-select or frame-sync line (`ws`) and a serial data line (`sd`). It is always the clock master. A divider on the system clock produces `sck`, and a slot sequencer divides each frame into word slots of `SLOT_W` bit periods. Within each word slot, a bit mapper places the active word at the offset that the selected framing calls for. The mapper supports two-channel standard framing, left-justified, right-justified, PCM with a short sync pulse, and PCM with a long sync pulse.

Samples come in on a valid/ready handshake. One sample is taken at the start of every word slot. If no sample is offered at that moment, the word is sent as zeros and a one-cycle underrun pulse is raised. Several options are set at run time: the word size, the number of words per frame (used by the PCM framings only), the bit order, the inversion of `sck` and of `ws`, and gating of `sck`. All configuration inputs are expected to stay constant while `cfg_enable` is high.

Top module: `audio_serial_tx`

## Requirements
- R1: While `cfg_enable` is low, the outputs rest at idle: `sd` = 0, logical `ws` = 0 (so the pin equals `cfg_ws_inv`), `sck` sits at its non-sampling level, `s_ready` = 0 and `underrun` = 0.
- R2: One bit period lasts 2*(`cfg_half_div`+1) system clocks. `sd` and `ws` change only at the start of a bit period and stay stable at the sampling edge. Before inversion, the sampling edge is the rising edge of `sck` for format codes 0, 3 and 4, and the falling edge for codes 1 and 2. The idle `sck` level is the level held just before that sampling edge.
- R3: Format code 0 (two-channel standard): `ws` is 0 for word 0 (left) and 1 for word 1 (right). It changes at slot position 0, and the MSB is sent at slot position 1.
- R4: Format code 3 (left-justified): `ws` is 1 for word 0 and 0 for word 1, and the MSB is sent at slot position 0.
- R5: Format code 4 (right-justified): `ws` is as in R4. The last word bit is sent at slot position `SLOT_W`-1, and the positions before the word carry 0.
- R6: Format code 1 (PCM short sync): `ws` is 1 only at slot position 0 of word 0. Each word starts at slot position 1, and a frame holds `cfg_words` words back to back.
- R7: Format code 2 (PCM long sync): `ws` is 1 at slot positions 0 to `SLOT_W`/2-1 of word 0 and 0 elsewhere. The MSB is sent at slot position 0.
- R8: For codes 0, 3 and 4 the value of `cfg_words` has no effect, and every frame holds exactly 2 words.
- R9: When `cfg_lsb_first` = 1, each word is sent starting from bit 0 instead of bit `cfg_word_bits`-1.
- R10: `cfg_sck_inv` = 1 inverts the `sck` pin and `cfg_ws_inv` = 1 inverts the `ws` pin. Neither changes the data that is sent.
- R11: With `cfg_gate_sck` = 1, `sck` makes sampling edges only in bit periods that carry a word bit. In all other periods it holds its idle level.
- R12: Every slot position outside the word is sent as 0. Bits of `s_data` at or above `cfg_word_bits` are ignored; the word sits in `s_data[cfg_word_bits-1:0]`.
- R13: `s_ready` is a one-cycle pulse at the start of each word slot. The sample offered with `s_valid` in that cycle is the word sent in that slot.
- R14: If `s_valid` is low when `s_ready` pulses, the word is sent as all zeros and `underrun` is high for exactly the next system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Runs the stream; low returns the block to idle |
| cfg_format | input | 3 | Framing code (0 std, 1 PCM short, 2 PCM long, 3 left-justified, 4 right-justified) |
| cfg_word_bits | input | $clog2(MAX_WORD+1) | Word size in bits, 1 to MAX_WORD |
| cfg_words | input | $clog2(MAX_WORDS+1) | Words per frame for the PCM framings |
| cfg_half_div | input | DIV_W | System clocks per sck half period, minus one |
| cfg_lsb_first | input | 1 | Sends bit 0 first |
| cfg_sck_inv | input | 1 | Inverts the sck pin |
| cfg_ws_inv | input | 1 | Inverts the ws pin |
| cfg_gate_sck | input | 1 | Lets sck toggle only in bit periods that carry data |
| s_valid | input | 1 | Sample offered |
| s_data | input | MAX_WORD | Sample, right-aligned |
| s_ready | output | 1 | Sample taken this cycle |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select or frame sync |
| sd | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse: a word started without a sample |

## Verification
The clock edge that fetches a new sample is the same edge that starts a new word slot. On that edge `ws` may toggle and the first slot position is driven, so the handshake result and the framing decision land in the same cycle. The bench provokes this by offering fewer samples than the frame needs while the two-channel framing toggles `ws` at every slot start. It then checks that the word which started without a sample is sent as zeros while still carrying the correct `ws` level, and that the number of underrun pulses is exactly one less than the number of ready pulses.

// File: rtl/ast_pkg.sv
package ast_pkg;

   typedef enum logic [2:0] {
      FMT_STD       = 3'd0,
      FMT_PCM_SHORT = 3'd1,
      FMT_PCM_LONG  = 3'd2,
      FMT_LEFT      = 3'd3,
      FMT_RIGHT     = 3'd4
   } ast_fmt_e;

   // PCM framings sample on the falling edge and idle high
   function automatic logic fmt_is_pcm(input logic [2:0] f);
      return (f == FMT_PCM_SHORT) || (f == FMT_PCM_LONG);
   endfunction

   // Channel framings that always carry two words per frame
   function automatic logic fmt_is_pair(input logic [2:0] f);
      return (f == FMT_STD) || (f == FMT_LEFT) || (f == FMT_RIGHT);
   endfunction

endpackage

// File: rtl/ast_slot_seq.sv
module ast_slot_seq #(
   parameter int SLOT_W    = 32,
   parameter int MAX_WORDS = 8,
   parameter int DIV_W     = 8,
   localparam int PW  = $clog2(SLOT_W),
   localparam int XW  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
   localparam int NWW = $clog2(MAX_WORDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [DIV_W-1:0] half_div,
   input  logic [NWW-1:0]   nwords,
   output logic             run,
   output logic             half,
   output logic [PW-1:0]    pos,
   output logic [XW-1:0]    widx,
   output logic             load
);

   logic [DIV_W-1:0] div_q;
   logic half_end, slot_end, last_pos, last_word;

   assign half_end  = run && (div_q == half_div);
   assign slot_end  = half_end && half;
   assign last_pos  = (pos == PW'(SLOT_W - 1));
   assign last_word = (NWW'(widx) + NWW'(1)) >= nwords;
   assign load      = enable && (!run || (slot_end && last_pos));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         half  <= 1'b0;
         div_q <= '0;
         pos   <= '0;
         widx  <= '0;
      end else if (!enable) begin
         run   <= 1'b0;
         half  <= 1'b0;
         div_q <= '0;
         pos   <= '0;
         widx  <= '0;
      end else if (!run) begin
         run <= 1'b1;
      end else if (half_end) begin
         div_q <= '0;
         half  <= ~half;
         if (half) begin
            pos <= last_pos ? '0 : pos + PW'(1);
            if (last_pos)
               widx <= last_word ? '0 : widx + XW'(1);
         end
      end else begin
         div_q <= div_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/ast_bit_map.sv
module ast_bit_map
   import ast_pkg::*;
#(
   parameter int MAX_WORD  = 24,
   parameter int SLOT_W    = 32,
   parameter int MAX_WORDS = 8,
   localparam int PW  = $clog2(SLOT_W),
   localparam int XW  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
   localparam int WBW = $clog2(MAX_WORD + 1),
   localparam int CW  = PW + 2
) (
   input  logic [2:0]          fmt,
   input  logic [WBW-1:0]      wbits,
   input  logic                lsb_first,
   input  logic                sck_inv,
   input  logic                ws_inv,
   input  logic                gate,
   input  logic                run,
   input  logic                half,
   input  logic [PW-1:0]       pos,
   input  logic [XW-1:0]       widx,
   input  logic [MAX_WORD-1:0] word,
   output logic                sck_n,
   output logic                ws_n,
   output logic                sd_n
);

   logic [CW-1:0]       w_c, off, p_c, k;
   logic [WBW-1:0]      bit_idx;
   logic [MAX_WORD-1:0] shifted;
   logic                in_win, pcm, ws_l, base;

   assign pcm = fmt_is_pcm(fmt);
   assign w_c = CW'(wbits);
   assign p_c = CW'(pos);

   always_comb begin
      case (fmt)
         FMT_STD, FMT_PCM_SHORT: off = CW'(1);
         FMT_RIGHT:              off = CW'(SLOT_W) - w_c;
         default:                off = '0;
      endcase
   end

   assign in_win  = (p_c >= off) && (p_c < off + w_c);
   assign k       = p_c - off;
   assign bit_idx = lsb_first ? WBW'(k) : WBW'(w_c - CW'(1) - k);
   assign shifted = word >> bit_idx;

   always_comb begin
      case (fmt)
         FMT_STD:             ws_l = widx[0];
         FMT_LEFT, FMT_RIGHT: ws_l = ~widx[0];
         FMT_PCM_SHORT:       ws_l = (widx == '0) && (pos == '0);
         FMT_PCM_LONG:        ws_l = (widx == '0) && (p_c < CW'(SLOT_W / 2));
         default:             ws_l = 1'b0;
      endcase
   end

   // Slot first half sits at the idle level; the sampling edge falls mid-slot
   assign base  = (!run || (gate && !in_win)) ? pcm : (half ^ pcm);
   assign sck_n = base ^ sck_inv;
   assign ws_n  = (run & ws_l) ^ ws_inv;
   assign sd_n  = run && in_win && shifted[0];

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
   import ast_pkg::*;
#(
   parameter int MAX_WORD  = 24,
   parameter int SLOT_W    = 32,
   parameter int MAX_WORDS = 8,
   parameter int DIV_W     = 8,
   localparam int PW  = $clog2(SLOT_W),
   localparam int XW  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
   localparam int WBW = $clog2(MAX_WORD + 1),
   localparam int NWW = $clog2(MAX_WORDS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_enable,
   input  logic [2:0]          cfg_format,
   input  logic [WBW-1:0]      cfg_word_bits,
   input  logic [NWW-1:0]      cfg_words,
   input  logic [DIV_W-1:0]    cfg_half_div,
   input  logic                cfg_lsb_first,
   input  logic                cfg_sck_inv,
   input  logic                cfg_ws_inv,
   input  logic                cfg_gate_sck,
   input  logic                s_valid,
   input  logic [MAX_WORD-1:0] s_data,
   output logic                s_ready,
   output logic                sck,
   output logic                ws,
   output logic                sd,
   output logic                underrun
);

   // Elaboration-time parameter checks
   if (SLOT_W <= MAX_WORD) begin : g_bad_slot
      $error("SLOT_W must exceed MAX_WORD to leave the one-period delayed slot");
   end
   if (MAX_WORDS < 2) begin : g_bad_words
      $error("MAX_WORDS must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic [WBW-1:0]      wbits_c;
   logic [NWW-1:0]      nwords_c;
   logic                run, half, load;
   logic [PW-1:0]       pos;
   logic [XW-1:0]       widx;
   logic [MAX_WORD-1:0] word_q;
   logic                sck_n, ws_n, sd_n;

   assign wbits_c = (cfg_word_bits == '0) ? WBW'(1) :
                    (cfg_word_bits > WBW'(MAX_WORD)) ? WBW'(MAX_WORD) : cfg_word_bits;

   assign nwords_c = fmt_is_pair(cfg_format) ? NWW'(2) :
                     (cfg_words == '0) ? NWW'(1) :
                     (cfg_words > NWW'(MAX_WORDS)) ? NWW'(MAX_WORDS) : cfg_words;

   ast_slot_seq #(.SLOT_W(SLOT_W), .MAX_WORDS(MAX_WORDS), .DIV_W(DIV_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (cfg_enable),
      .half_div (cfg_half_div),
      .nwords   (nwords_c),
      .run      (run),
      .half     (half),
      .pos      (pos),
      .widx     (widx),
      .load     (load)
   );

   ast_bit_map #(.MAX_WORD(MAX_WORD), .SLOT_W(SLOT_W), .MAX_WORDS(MAX_WORDS)) u_map (
      .fmt       (cfg_format),
      .wbits     (wbits_c),
      .lsb_first (cfg_lsb_first),
      .sck_inv   (cfg_sck_inv),
      .ws_inv    (cfg_ws_inv),
      .gate      (cfg_gate_sck),
      .run       (run),
      .half      (half),
      .pos       (pos),
      .widx      (widx),
      .word      (word_q),
      .sck_n     (sck_n),
      .ws_n      (ws_n),
      .sd_n      (sd_n)
   );

   assign s_ready = load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= '0;
         underrun <= 1'b0;
         sck      <= 1'b0;
         ws       <= 1'b0;
         sd       <= 1'b0;
      end else begin
         if (load)
            word_q <= s_valid ? s_data : '0;
         underrun <= load && !s_valid;
         sck      <= sck_n;
         ws       <= ws_n;
         sd       <= sd_n;
      end
   end

endmodule

// File: rtl/audio_serial_tx_chk.sv
module audio_serial_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_enable,
   input logic [2:0] cfg_format,
   input logic       cfg_sck_inv,
   input logic       s_valid,
   input logic       s_ready,
   input logic       sck,
   input logic       ws,
   input logic       sd,
   input logic       underrun
);

   logic fall_samples;
   assign fall_samples = ((cfg_format == 3'd1) || (cfg_format == 3'd2)) ^ cfg_sck_inv;

   // R2
   sample_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_enable && $past(cfg_enable) && (fall_samples ? $fell(sck) : $rose(sck)))
      |-> ($stable(sd) && $stable(ws)));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_enable && $past(!cfg_enable)) |-> (!sd && !s_ready && !underrun));

   // R13
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |=> !s_ready);

   // R14
   underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> $past(s_ready && !s_valid));

   // R14
   underrun_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> !underrun);

endmodule

bind audio_serial_tx audio_serial_tx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_enable  (cfg_enable),
   .cfg_format  (cfg_format),
   .cfg_sck_inv (cfg_sck_inv),
   .s_valid     (s_valid),
   .s_ready     (s_ready),
   .sck         (sck),
   .ws          (ws),
   .sd          (sd),
   .underrun    (underrun)
);

// File: tb/tb_audio_serial_tx.sv
module tb_audio_serial_tx;

   localparam int MW  = 16;
   localparam int SW  = 18;
   localparam int MX  = 4;
   localparam int DW  = 4;
   localparam int WBW = $clog2(MW + 1);
   localparam int NWW = $clog2(MX + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_enable = 1'b0;
   logic [2:0] cfg_format = 3'd0;
   logic [WBW-1:0] cfg_word_bits = WBW'(16);
   logic [NWW-1:0] cfg_words = NWW'(2);
   logic [DW-1:0] cfg_half_div = DW'(1);
   logic cfg_lsb_first = 1'b0, cfg_sck_inv = 1'b0, cfg_ws_inv = 1'b0, cfg_gate_sck = 1'b0;
   logic s_valid, s_ready, sck, ws, sd, underrun;
   logic [MW-1:0] s_data;

   logic [MW-1:0] src [0:7];
   int src_n = 0, src_i = 0, rdy_cnt = 0, und_cnt = 0, cyc = 0;
   logic feed = 1'b0;

   logic cap_on = 1'b0, t_pcm = 1'b0, t_sinv = 1'b0, t_winv = 1'b0, eff_prev = 1'b0;
   logic cap_sd [0:127];
   logic cap_ws [0:127];
   int   cap_t  [0:127];
   int   cap_n = 0;

   int errors = 0, checks = 0;
   logic done = 1'b0;

   always #2 clk = ~clk;

   assign s_valid = feed && (src_i < src_n);
   assign s_data  = (src_i < 8) ? src[src_i] : '0;

   audio_serial_tx #(.MAX_WORD(MW), .SLOT_W(SW), .MAX_WORDS(MX), .DIV_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_format(cfg_format),
      .cfg_word_bits(cfg_word_bits), .cfg_words(cfg_words), .cfg_half_div(cfg_half_div),
      .cfg_lsb_first(cfg_lsb_first), .cfg_sck_inv(cfg_sck_inv), .cfg_ws_inv(cfg_ws_inv),
      .cfg_gate_sck(cfg_gate_sck), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
      .sck(sck), .ws(ws), .sd(sd), .underrun(underrun)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (s_ready && s_valid) src_i <= src_i + 1;
      if (s_ready) rdy_cnt <= rdy_cnt + 1;
      if (underrun) und_cnt <= und_cnt + 1;
   end

   // Receiver model: capture sd and logical ws at each sampling edge
   always @(negedge clk) begin
      logic eff;
      eff = sck ^ t_sinv;
      if (cap_on && cap_n < 128 &&
          ((t_pcm && eff_prev && !eff) || (!t_pcm && !eff_prev && eff))) begin
         cap_sd[cap_n] = sd;
         cap_ws[cap_n] = ws ^ t_winv;
         cap_t[cap_n]  = cyc;
         cap_n = cap_n + 1;
      end
      eff_prev = eff;
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL R2 watchdog: actual cycles=%0d expected < 150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic check(input string tag, input bit ok, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s", tag, what);
      end
   endtask

   task automatic check_reset();
      repeat (4) @(negedge clk);
      check("R1", sck === 1'b0 && ws === 1'b0 && sd === 1'b0,
            $sformatf("idle pins: actual sck=%b ws=%b sd=%b expected 0 0 0", sck, ws, sd));
      check("R1", s_ready === 1'b0 && underrun === 1'b0,
            $sformatf("idle handshake: actual ready=%b underrun=%b expected 0 0", s_ready, underrun));
      // R10 idle levels with inversion on a falling-sampled framing
      cfg_format = 3'd1; cfg_sck_inv = 1'b1; cfg_ws_inv = 1'b1;
      repeat (3) @(negedge clk);
      check("R10", sck === 1'b0 && ws === 1'b1,
            $sformatf("inverted idle: actual sck=%b ws=%b expected 0 1", sck, ws));
      cfg_format = 3'd0; cfg_sck_inv = 1'b0; cfg_ws_inv = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic run_case(input string tag, input int fmt, input int wb, input int nwc,
                           input bit lsb, input bit sinv, input bit winv, input bit gate,
                           input int hd, input int nsamp);
      int nwe, total, guard, c, mask;
      bit pcm;
      pcm   = (fmt == 1) || (fmt == 2);
      nwe   = pcm ? nwc : 2;
      total = gate ? 2 * nwe * wb : 2 * nwe * SW;
      mask  = (1 << wb) - 1;
      for (int j = 0; j < 8; j++) src[j] = MW'(32'hB5E3 + j * 32'h2F69);
      @(negedge clk);
      cfg_format = 3'(fmt); cfg_word_bits = WBW'(wb); cfg_words = NWW'(nwc);
      cfg_lsb_first = lsb; cfg_sck_inv = sinv; cfg_ws_inv = winv; cfg_gate_sck = gate;
      cfg_half_div = DW'(hd);
      t_pcm = pcm; t_sinv = sinv; t_winv = winv;
      src_n = nsamp; src_i = 0; rdy_cnt = 0; und_cnt = 0; cap_n = 0;
      repeat (3) @(negedge clk);
      eff_prev = sck ^ sinv;
      cap_on = 1'b1; feed = 1'b1;
      cfg_enable = 1'b1;
      guard = 0;
      while (cap_n < total && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      cfg_enable = 1'b0; cap_on = 1'b0;
      repeat (4) @(negedge clk);
      feed = 1'b0;
      check(tag, cap_n >= total,
            $sformatf("sampling edges: actual=%0d expected=%0d", cap_n, total));
      if (!gate)
         check("R2", cap_n > 1 && (cap_t[1] - cap_t[0]) == 2 * (hd + 1),
               $sformatf("bit period: actual=%0d expected=%0d", cap_t[1] - cap_t[0], 2 * (hd + 1)));
      c = 0;
      for (int j = 0; j < 2 * nwe; j++) begin
         int m, wi, off, k;
         bit bad, in, eb, ew;
         string msg;
         m   = (j < nsamp) ? (int'(src[j]) & mask) : 0;
         wi  = j % nwe;
         off = (fmt == 0 || fmt == 1) ? 1 : (fmt == 4) ? SW - wb : 0;
         bad = 1'b0; msg = "";
         for (int p = 0; p < SW; p++) begin
            in = (p >= off) && (p < off + wb);
            if (gate && !in) continue;
            k  = p - off;
            eb = in ? 1'(m >> (lsb ? k : wb - 1 - k)) : 1'b0;
            case (fmt)
               0:       ew = 1'(wi & 1);
               1:       ew = (wi == 0) && (p == 0);
               2:       ew = (wi == 0) && (p < SW / 2);
               default: ew = !(1'(wi & 1));
            endcase
            if (c < cap_n && !bad && (cap_sd[c] !== eb || cap_ws[c] !== ew)) begin
               bad = 1'b1;
               msg = $sformatf("word %0d pos %0d: actual sd=%b ws=%b expected sd=%b ws=%b",
                               j, p, cap_sd[c], cap_ws[c], eb, ew);
            end
            c++;
         end
         check(tag, !bad, msg);
      end
      if (nsamp >= 2 * nwe + 1) begin
         check("R13", und_cnt == 0 && rdy_cnt >= 2 * nwe,
               $sformatf("handshake: actual underruns=%0d readies=%0d expected 0 and >=%0d",
                         und_cnt, rdy_cnt, 2 * nwe));
      end else begin
         check("R14", und_cnt == rdy_cnt - nsamp && und_cnt > 0,
               $sformatf("underrun pulses: actual=%0d expected=%0d", und_cnt, rdy_cnt - nsamp));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_reset();
      run_case("R3/R8", 0, 16, 3, 0, 0, 0, 0, 1, 7);
      run_case("R4/R12", 3, 12, 2, 0, 0, 0, 0, 1, 7);
      run_case("R5/R12", 4, 12, 2, 0, 0, 0, 0, 0, 7);
      run_case("R6", 1, 8, 3, 0, 0, 0, 0, 1, 7);
      run_case("R7", 2, 10, 2, 0, 0, 0, 0, 2, 7);
      run_case("R9", 0, 16, 2, 1, 0, 0, 0, 1, 7);
      run_case("R10", 3, 12, 2, 0, 1, 1, 0, 1, 7);
      run_case("R11", 3, 12, 2, 0, 0, 0, 1, 1, 7);
      run_case("R11", 1, 8, 2, 1, 1, 0, 1, 1, 7);
      run_case("R14", 0, 16, 2, 0, 0, 0, 0, 1, 1);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule